// File: doc/BRIEF.md
# Two-Plane Hardware Cursor Overlay

This block places a 64x64 pointer image on top of the outgoing pixel stream. The image is stored in frame memory as two one-bit planes: a mask plane that decides whether the screen pixel is kept, and an invert plane that is XORed onto the result. Each cursor row takes 16 bytes. The 8 mask bytes come first and the 8 invert bytes follow. A small register write port sets the cursor position, the image base address (in 256-byte units) and an enable bit.

At the start of every raster line the block checks whether the line crosses the cursor. If it does, the block issues one read of that cursor row from frame memory and latches the returned planes. If it does not, the block loads a transparent row instead. During the line, each valid screen pixel is combined with the matching cursor column and appears on the output one cycle later. The position registers are shadowed and become active only on a frame-start strobe, so the cursor never tears in the middle of a frame.

Top module: `cursorOverlay`

## Requirements
- R1: While reset is asserted and in the cycle after it, `outValid` and `memRdReq` are 0. After reset the cursor is disabled, so pixels pass through unchanged.
- R2: Register writes use `regIdx`, with each index selecting one register:
  - 0: X low byte
  - 1: X bits 10:8 (taken from data bits 2:0)
  - 2: Y low byte
  - 3: Y bits 10:8 (taken from data bits 2:0)
  - 4: base low byte
  - 5: base bits 13:8 (taken from data bits 5:0)
  - 6: control, where bit 0 is the enable

  A write to index 7 has no effect.
- R3: X and Y writes go to shadow registers. They take effect only after a `frameStart` pulse. Lines before that pulse still use the previous position.
- R4: A `lineStart` pulse whose `rasterY` lies in [Y, Y+63] while the cursor is enabled makes `memRdReq` high for exactly one cycle, in the next cycle. The address `memRdAddr` equals base*256 + (rasterY-Y)*16, taken modulo 2^22.
- R5: A `lineStart` pulse whose line is outside the cursor rows, or that arrives while the cursor is disabled, issues no read. That line is passed through unchanged.
- R6: In the returned row, byte i sits at `memRdData[8i+7:8i]`. Bytes 0-7 form the mask plane and bytes 8-15 form the invert plane. Bit 7 of each byte is the leftmost of its 8 pixels.
- R7: For a pixel inside the window, the output is (screen AND mask-bit replicated) XOR invert-bit replicated. A mask bit of 1 with an invert bit of 0 leaves the pixel unchanged.
- R8: Only pixels with `rasterX` in [X, X+63] are modified; all others pass through. Each valid input pixel produces `outValid` with its result exactly one cycle later.
- R9: Clearing the enable bit takes effect immediately, even in the middle of a line that already fetched its row: later pixels pass through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regIdx | input | 3 | Register index |
| regWrData | input | 8 | Register write data |
| frameStart | input | 1 | Frame-start pulse; loads shadow position |
| lineStart | input | 1 | Line-start pulse; triggers row lookup |
| rasterY | input | 11 | Line number for the current line |
| pixValid | input | 1 | Screen pixel valid |
| rasterX | input | 11 | Column of the screen pixel |
| screenPix | input | 8 | Underlying screen pixel |
| memRdValid | input | 1 | Row read data valid |
| memRdData | input | 128 | 16-byte cursor row |
| memRdReq | output | 1 | Row read request pulse |
| memRdAddr | output | 22 | Byte address of the cursor row |
| outValid | output | 1 | Output pixel valid |
| outPix | output | 8 | Combined output pixel |

## Verification
The assertions assume several things about the inputs:
- `lineStart` arrives only when no row read is pending.
- `frameStart` never falls in the same cycle as a `lineStart`.
- Memory answers each request with exactly one `memRdValid` pulse.

The stimulus keeps within these limits because it drives each line as a fixed sequence: start pulse, the request check, a single response two cycles after the start, and then pixels one per cycle. Random positions and base addresses are drawn with the base kept 1 KB aligned. Random lines and columns are placed within a few pixels of the cursor edges, so both sides of every window bound are hit.

// File: rtl/cursorOverlayPkg.sv
package cursorOverlayPkg;
  typedef struct packed {
    logic issueFetch;
    logic loadRow;
    logic loadClear;
    logic latchPos;
  } curStrobes_t;
endpackage

// File: rtl/cursorCtrl.sv
module cursorCtrl
  import cursorOverlayPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineStart,
  input  logic        frameStart,
  input  logic        rowHit,
  input  logic        memRdValid,
  output curStrobes_t strobes,
  output logic        memRdReq
);
  typedef enum logic {ST_IDLE, ST_WAIT} ctrlState_t;
  ctrlState_t state;

  always_comb begin
    strobes.issueFetch = (state == ST_IDLE) && lineStart && rowHit;
    strobes.loadClear  = (state == ST_IDLE) && lineStart && !rowHit;
    strobes.loadRow    = (state == ST_WAIT) && memRdValid;
    strobes.latchPos   = frameStart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      memRdReq <= 1'b0;
    end else begin
      memRdReq <= strobes.issueFetch;
      if (strobes.issueFetch)   state <= ST_WAIT;
      else if (strobes.loadRow) state <= ST_IDLE;
    end
  end
endmodule

// File: rtl/cursorDatapath.sv
module cursorDatapath
  import cursorOverlayPkg::*;
#(
  parameter int PIX_W      = 8,
  parameter int COORD_W    = 11,
  parameter int BASE_W     = 14,
  parameter int BASE_SHIFT = 8,
  parameter int CUR_SIZE   = 64,
  localparam int ADDR_W    = BASE_W + BASE_SHIFT,
  localparam int DATA_W    = 2 * CUR_SIZE * CUR_SIZE / CUR_SIZE,
  localparam int ROW_W     = $clog2(CUR_SIZE)
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [2:0]         regIdx,
  input  logic [7:0]         regWrData,
  input  curStrobes_t        strobes,
  input  logic [COORD_W-1:0] rasterY,
  input  logic               pixValid,
  input  logic [COORD_W-1:0] rasterX,
  input  logic [PIX_W-1:0]   screenPix,
  input  logic [DATA_W-1:0]  memRdData,
  output logic               rowHit,
  output logic [ADDR_W-1:0]  memRdAddr,
  output logic               outValid,
  output logic [PIX_W-1:0]   outPix
);
  localparam int ROW_BYTES = DATA_W / 8;
  localparam int BYTE_SH   = $clog2(ROW_BYTES);

  logic [COORD_W-1:0] shadowX, shadowY, actX, actY;
  logic [BASE_W-1:0]  baseReg;
  logic               enable;
  logic [CUR_SIZE-1:0] andRow, xorRow, andNext, xorNext;

  // register write port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowX <= '0; shadowY <= '0; baseReg <= '0; enable <= 1'b0;
    end else if (regWrEn) begin
      case (regIdx)
        3'd0: shadowX[7:0]         <= regWrData;
        3'd1: shadowX[COORD_W-1:8] <= regWrData[COORD_W-9:0];
        3'd2: shadowY[7:0]         <= regWrData;
        3'd3: shadowY[COORD_W-1:8] <= regWrData[COORD_W-9:0];
        3'd4: baseReg[7:0]         <= regWrData;
        3'd5: baseReg[BASE_W-1:8]  <= regWrData[BASE_W-9:0];
        3'd6: enable               <= regWrData[0];
        default: ;
      endcase
    end
  end

  // active position, loaded at frame start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actX <= '0; actY <= '0;
    end else if (strobes.latchPos) begin
      actX <= shadowX; actY <= shadowY;
    end
  end

  // row compare and fetch address
  logic [COORD_W:0]    rowOff;
  logic [ROW_W-1:0]    rowIdx;
  logic [ADDR_W-1:0]   fetchAddr;
  always_comb begin
    rowOff    = {1'b0, rasterY} - {1'b0, actY};
    rowIdx    = rowOff[ROW_W-1:0];
    rowHit    = enable && !rowOff[COORD_W] && (rowOff < (COORD_W+1)'(CUR_SIZE));
    fetchAddr = {baseReg, {BASE_SHIFT{1'b0}}} + (ADDR_W'(rowIdx) << BYTE_SH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) memRdAddr <= '0;
    else if (strobes.issueFetch) memRdAddr <= fetchAddr;
  end

  // unpack planes: column c uses byte c/8, bit 7 - c%8
  for (genvar c = 0; c < CUR_SIZE; c++) begin : g_col
    assign andNext[c] = memRdData[8*(c/8) + 7 - (c%8)];
    assign xorNext[c] = memRdData[CUR_SIZE + 8*(c/8) + 7 - (c%8)];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      andRow <= '1; xorRow <= '0;
    end else if (strobes.loadRow) begin
      andRow <= andNext; xorRow <= xorNext;
    end else if (strobes.loadClear) begin
      andRow <= '1; xorRow <= '0;
    end
  end

  // pixel combine
  logic [COORD_W:0] colOff;
  logic [ROW_W-1:0] col;
  logic             inWin;
  logic [PIX_W-1:0] mixPix;
  always_comb begin
    colOff = {1'b0, rasterX} - {1'b0, actX};
    col    = colOff[ROW_W-1:0];
    inWin  = enable && !colOff[COORD_W] && (colOff < (COORD_W+1)'(CUR_SIZE));
    mixPix = inWin ? ((screenPix & {PIX_W{andRow[col]}}) ^ {PIX_W{xorRow[col]}})
                   : screenPix;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0; outPix <= '0;
    end else begin
      outValid <= pixValid;
      if (pixValid) outPix <= mixPix;
    end
  end
endmodule

// File: rtl/cursorOverlay.sv
module cursorOverlay
  import cursorOverlayPkg::*;
#(
  parameter int PIX_W      = 8,
  parameter int COORD_W    = 11,
  parameter int BASE_W     = 14,
  parameter int BASE_SHIFT = 8,
  parameter int CUR_SIZE   = 64,
  localparam int ADDR_W    = BASE_W + BASE_SHIFT,
  localparam int DATA_W    = 2 * CUR_SIZE
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [2:0]         regIdx,
  input  logic [7:0]         regWrData,
  input  logic               frameStart,
  input  logic               lineStart,
  input  logic [COORD_W-1:0] rasterY,
  input  logic               pixValid,
  input  logic [COORD_W-1:0] rasterX,
  input  logic [PIX_W-1:0]   screenPix,
  input  logic               memRdValid,
  input  logic [DATA_W-1:0]  memRdData,
  output logic               memRdReq,
  output logic [ADDR_W-1:0]  memRdAddr,
  output logic               outValid,
  output logic [PIX_W-1:0]   outPix
);
  curStrobes_t strobes;
  logic        rowHit;

  cursorCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .frameStart(frameStart),
    .rowHit(rowHit), .memRdValid(memRdValid), .strobes(strobes), .memRdReq(memRdReq)
  );

  cursorDatapath #(
    .PIX_W(PIX_W), .COORD_W(COORD_W), .BASE_W(BASE_W),
    .BASE_SHIFT(BASE_SHIFT), .CUR_SIZE(CUR_SIZE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regIdx(regIdx), .regWrData(regWrData),
    .strobes(strobes), .rasterY(rasterY), .pixValid(pixValid), .rasterX(rasterX),
    .screenPix(screenPix), .memRdData(memRdData), .rowHit(rowHit),
    .memRdAddr(memRdAddr), .outValid(outValid), .outPix(outPix)
  );
endmodule

// File: rtl/cursorOverlayChk.sv
module cursorOverlayChk #(
  parameter int ADDR_W  = 22,
  parameter int BYTE_SH = 4
)(
  input logic              clk,
  input logic              rstN,
  input logic              lineStart,
  input logic              pixValid,
  input logic              rowHit,
  input logic              memRdReq,
  input logic [ADDR_W-1:0] memRdAddr,
  input logic              outValid
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!outValid && !memRdReq));

  assert_req_after_line_R4: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |-> $past(lineStart));

  assert_req_single_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |=> !memRdReq);

  assert_req_needs_hit_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memRdReq) |-> $past(rowHit));

  assert_row_addr_aligned_R6: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |-> (memRdAddr[BYTE_SH-1:0] == '0));

  assert_out_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(pixValid));
endmodule

bind cursorOverlay cursorOverlayChk #(.ADDR_W(ADDR_W), .BYTE_SH($clog2(DATA_W/8))) chk_i (
  .clk(clk), .rstN(rstN), .lineStart(lineStart), .pixValid(pixValid),
  .rowHit(rowHit), .memRdReq(memRdReq), .memRdAddr(memRdAddr), .outValid(outValid)
);

// File: tb/cursorOverlay_tb.sv
module cursorOverlay_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 0; logic [2:0] regIdx = 0; logic [7:0] regWrData = 0;
  logic frameStart = 0, lineStart = 0, pixValid = 0, memRdValid = 0;
  logic [10:0] rasterY = 0, rasterX = 0;
  logic [7:0] screenPix = 0;
  logic [127:0] memRdData = '0;
  logic memRdReq, outValid;
  logic [21:0] memRdAddr;
  logic [7:0] outPix;

  always #5 clk = ~clk;

  cursorOverlay dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regIdx(regIdx), .regWrData(regWrData),
    .frameStart(frameStart), .lineStart(lineStart), .rasterY(rasterY),
    .pixValid(pixValid), .rasterX(rasterX), .screenPix(screenPix),
    .memRdValid(memRdValid), .memRdData(memRdData), .memRdReq(memRdReq),
    .memRdAddr(memRdAddr), .outValid(outValid), .outPix(outPix)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int shX = 0, shY = 0, acX = 0, acY = 0, baseV = 0;
  bit enV = 0;
  logic [63:0] andP = '1, xorP = '0;

  function automatic logic [7:0] memByte(input int a);
    return 8'((a * 29) ^ (a >>> 3) ^ 166);
  endfunction

  function automatic logic [7:0] expPix(input int x, input logic [7:0] s);
    if (enV && x >= acX && x - acX < 64)
      return (s & {8{andP[x - acX]}}) ^ {8{xorP[x - acX]}};
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input int idx, input int data);
    regWrEn = 1; regIdx = 3'(idx); regWrData = 8'(data);
    @(negedge clk); regWrEn = 0;
    case (idx)
      0: shX = (shX & 'h700) | (data & 'hFF);
      1: shX = (shX & 'hFF) | ((data & 7) << 8);
      2: shY = (shY & 'h700) | (data & 'hFF);
      3: shY = (shY & 'hFF) | ((data & 7) << 8);
      4: baseV = (baseV & 'h3F00) | (data & 'hFF);
      5: baseV = (baseV & 'hFF) | ((data & 'h3F) << 8);
      6: enV = data[0];
      default: ;
    endcase
  endtask

  task automatic setCursor(input int x, input int y, input int b, input bit e);
    regWrite(0, x); regWrite(1, x >> 8); regWrite(2, y); regWrite(3, y >> 8);
    regWrite(4, b); regWrite(5, b >> 8); regWrite(6, e);
  endtask

  task automatic frame();
    frameStart = 1; @(negedge clk); frameStart = 0;
    acX = shX; acY = shY;
    @(negedge clk);
  endtask

  task automatic doLine(input int y);
    bit hit, sawReq;
    int expAddr, gotAddr;
    hit = enV && y >= acY && y - acY < 64;
    expAddr = ((baseV << 8) + (y - acY) * 16) & 'h3FFFFF;
    rasterY = 11'(y); lineStart = 1;
    @(negedge clk); lineStart = 0;
    sawReq = memRdReq;
    check(sawReq == hit, hit ? "R4 request" : "R5 no request", sawReq, hit);
    if (hit) begin
      andP = '1; xorP = '0;
      for (int c = 0; c < 64; c++) begin
        andP[c] = memByte(expAddr + c / 8)[7 - c % 8];
        xorP[c] = memByte(expAddr + 8 + c / 8)[7 - c % 8];
      end
    end else begin
      andP = '1; xorP = '0;
    end
    if (sawReq) begin
      gotAddr = int'(memRdAddr);
      if (hit) check(gotAddr == expAddr, "R4 address", gotAddr, expAddr);
      @(negedge clk);
      check(memRdReq == 0, "R4 single pulse", memRdReq, 0);
      for (int i = 0; i < 16; i++) memRdData[8*i +: 8] = memByte(gotAddr + i);
      memRdValid = 1;
      @(negedge clk); memRdValid = 0;
    end
    @(negedge clk);
  endtask

  task automatic pix(input int x, input logic [7:0] s, input string req);
    logic [7:0] e;
    e = expPix(x, s);
    pixValid = 1; rasterX = 11'(x); screenPix = s;
    @(negedge clk); pixValid = 0;
    check(outValid == 1, "R8 output valid", outValid, 1);
    check(outPix == e, req, outPix, e);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(outValid == 0, "R1 outValid in reset", outValid, 0);
    check(memRdReq == 0, "R1 memRdReq in reset", memRdReq, 0);
    rstN = 1;
    @(negedge clk);

    // disabled after reset
    doLine(0);
    pix(0, 8'h3C, "R1 pass-through after reset");

    // directed window corners
    setCursor(100, 50, 'h0104, 1);
    regWrite(7, 'hFF); // ignored index (R2)
    frame();
    doLine(50);
    pix(100, 8'hA5, "R7 column 0");
    pix(107, 8'h0F, "R6 byte 0 last bit");
    pix(108, 8'hF0, "R6 byte 1 first bit");
    pix(163, 8'h5A, "R7 column 63");
    pix(164, 8'h77, "R8 right of window");
    pix(99, 8'h77, "R8 left of window");
    doLine(113);
    pix(130, 8'hC3, "R7 last row");
    doLine(114);
    pix(130, 8'hC3, "R5 below window");
    doLine(49);
    pix(101, 8'h81, "R5 above window");

    // transparent code: mask 1, invert 0 leaves the pixel
    doLine(60);
    for (int x = 100; x < 164; x += 9) pix(x, 8'(x * 7), "R7 combine");

    // shadowed position
    regWrite(0, 300 & 'hFF); regWrite(1, 300 >> 8);
    doLine(60);
    pix(100, 8'h96, "R3 old position still active");
    pix(300, 8'h96, "R3 new position not yet active");
    frame();
    doLine(60);
    pix(300, 8'h96, "R3 new position active");
    pix(301, 8'h69, "R3 new position active");

    // enable cleared mid-line
    regWrite(6, 0);
    pix(305, 8'hE1, "R9 disable immediate");
    regWrite(6, 1);
    doLine(55);
    pix(310, 8'h1E, "R2 enable re-set");

    // random frames
    for (int f = 0; f < 10; f++) begin
      setCursor($urandom % 1900, $urandom % 1900, ($urandom % 'h3FFF) & 'h3FFC,
                ($urandom % 4) != 0);
      frame();
      for (int l = 0; l < 6; l++) begin
        int y;
        y = acY + int'($urandom % 80) - 8;
        if (y < 0) y = 0;
        doLine(y);
        for (int p = 0; p < 12; p++) begin
          int x;
          x = acX + int'($urandom % 80) - 8;
          if (x < 0) x = 0;
          pix(x, 8'($urandom), "R7 random");
        end
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule